// File: doc/BRIEF.md
# ROM Emulation Dual-Port Memory

This block is a 2048-byte store that two independent systems share at the same time. A development host reaches it through a decoded window on its own address bus and treats it as ordinary RAM. A target system reaches it through signals that stand in for a ROM or EPROM socket: address lines, chip enables and an output enable. On that side it only ever returns data. Code written by the host can therefore be run by the target at once, with no device to program.

A two-bit mode input selects the device that the socket side looks like. The choices are a single 1K part, a single 2K part, or a pair of 1K parts, each with its own chip enable. In 1K mode a bank input chooses which half of the store is seen. The socket data output is qualified by a drive-enable flag in place of a real tri-state pad.

Top module: `rom_emu_dpram`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `t_drive`, `h_rvalid`, `t_data` and `h_rdata` are all zero.
- R2: A host read (`h_re`=1, `h_we`=0) with `h_addr` in 0xC000–0xC7FF sets `h_rvalid` on the next cycle, and `h_rdata` holds the byte at offset `h_addr[10:0]`.
- R3: A host access with `h_addr` outside 0xC000–0xC7FF is ignored. A read gives no `h_rvalid`, and a write leaves every stored byte unchanged.
- R4: In mode 1 (2K part), when `t_ce0_n`=0 and `t_oe_n`=0, the next cycle has `t_drive`=1 and `t_data` equal to the byte at `t_addr[10:0]`. `t_ce1_n` is ignored.
- R5: When the socket is not selected (output enable high, or no chip enable active for the mode), the next cycle has `t_drive`=0 and `t_data`=0.
- R6: In mode 0 (1K part), selection uses `t_ce0_n` and `t_oe_n`, and the byte read is at `{bank_sel, t_addr[9:0]}`. `t_addr[10]` has no effect.
- R7: In mode 2 (two 1K parts), `t_ce0_n` low reads `{0, t_addr[9:0]}` and `t_ce1_n` low reads `{1, t_addr[9:0]}`. When both are low, `t_ce0_n` wins.
- R8: When a host write and a target read hit the same byte in the same cycle, the target returns the newly written byte (write-first).
- R9: Mode 3 is reserved, and the socket side never drives in it.
- R10: When `h_we` and `h_re` are both high, the write is performed and no read response (`h_rvalid`) is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 16 | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_we | input | 1 | Host write strobe |
| h_re | input | 1 | Host read strobe |
| h_rdata | output | 8 | Host read data, one cycle after the read |
| h_rvalid | output | 1 | Host read data valid |
| mode | input | 2 | Emulated device: 0 = 1K, 1 = 2K, 2 = two 1K, 3 = reserved |
| bank_sel | input | 1 | Half of the store shown in 1K mode |
| t_addr | input | 11 | Socket address lines |
| t_ce0_n | input | 1 | Socket chip enable (lower device), active low |
| t_ce1_n | input | 1 | Upper device chip enable in mode 2, active low |
| t_oe_n | input | 1 | Socket output enable, active low |
| t_data | output | 8 | Socket read data, zero when not driven |
| t_drive | output | 1 | Socket data drive enable |

## Verification
The bound checker watches the socket side on every cycle. It confirms that the data output is zero whenever it is not driven, that a high output enable, the reserved mode, or two idle chip enables in dual mode never cause a drive, and that a host read response only follows an accepted read inside the window. It also checks write-first on same-address collisions in 2K mode. The mapping of addresses in 1K and dual mode, the bank choice, chip-enable priority, and the fact that writes outside the window leave the store untouched are shown only by the bench's scenarios, because they need known stored contents.

// File: rtl/rom_emu_pkg.sv
package rom_emu_pkg;
    localparam int DATA_W   = 8;
    localparam int MEM_AW   = 11;
    localparam int MEM_DEPTH = 1 << MEM_AW;
    localparam int DEV_AW   = MEM_AW - 1;
    localparam int HOST_AW  = 16;
    localparam logic [HOST_AW-1:0] HOST_BASE = 16'hC000;
    localparam int TAG_W    = HOST_AW - MEM_AW;

    typedef enum logic [1:0] {
        MODE_SMALL = 2'd0,
        MODE_LARGE = 2'd1,
        MODE_PAIR  = 2'd2,
        MODE_RSVD  = 2'd3
    } dev_mode_e;

    typedef struct packed {
        logic              en;
        logic [MEM_AW-1:0] addr;
    } mem_req_t;

    function automatic logic in_window(input logic [HOST_AW-1:0] a);
        return a[HOST_AW-1:MEM_AW] == HOST_BASE[HOST_AW-1:MEM_AW];
    endfunction
endpackage

// File: rtl/rom_emu_host_dec.sv
module rom_emu_host_dec
    import rom_emu_pkg::*;
(
    input  logic [HOST_AW-1:0] h_addr,
    input  logic               h_we,
    input  logic               h_re,
    output mem_req_t           wr_req,
    output mem_req_t           rd_req
);
    logic hit;

    always_comb begin
        hit         = in_window(h_addr);
        wr_req.en   = h_we && hit;
        wr_req.addr = h_addr[MEM_AW-1:0];
        rd_req.en   = h_re && !h_we && hit;
        rd_req.addr = h_addr[MEM_AW-1:0];
    end
endmodule

// File: rtl/rom_emu_tgt_map.sv
module rom_emu_tgt_map
    import rom_emu_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic              bank_sel,
    input  logic [MEM_AW-1:0] t_addr,
    input  logic              t_ce0_n,
    input  logic              t_ce1_n,
    input  logic              t_oe_n,
    output mem_req_t          req
);
    dev_mode_e m;

    always_comb begin
        m        = dev_mode_e'(mode);
        req.en   = 1'b0;
        req.addr = t_addr;
        unique case (m)
            MODE_SMALL: begin
                req.en   = !t_ce0_n && !t_oe_n;
                req.addr = {bank_sel, t_addr[DEV_AW-1:0]};
            end
            MODE_LARGE: begin
                req.en   = !t_ce0_n && !t_oe_n;
                req.addr = t_addr;
            end
            MODE_PAIR: begin
                req.en   = (!t_ce0_n || !t_ce1_n) && !t_oe_n;
                req.addr = {t_ce0_n, t_addr[DEV_AW-1:0]};
            end
            MODE_RSVD: begin
                req.en   = 1'b0;
            end
            default: req.en = 1'b0;
        endcase
    end
endmodule

// File: rtl/rom_emu_store.sv
module rom_emu_store
    import rom_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mem_req_t          wr_req,
    input  logic [DATA_W-1:0] wdata,
    input  mem_req_t          hrd_req,
    input  mem_req_t          trd_req,
    output logic [DATA_W-1:0] h_q,
    output logic              h_v,
    output logic [DATA_W-1:0] t_q,
    output logic              t_v
);
    logic [DATA_W-1:0] mem [MEM_DEPTH];
    logic              collide;
    logic [DATA_W-1:0] t_next;

    always_comb begin
        collide = wr_req.en && (wr_req.addr == trd_req.addr);
        t_next  = collide ? wdata : mem[trd_req.addr];
    end

    always_ff @(posedge clk) begin
        if (wr_req.en) mem[wr_req.addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
            h_v <= 1'b0;
            t_q <= '0;
            t_v <= 1'b0;
        end else begin
            h_v <= hrd_req.en;
            if (hrd_req.en) h_q <= mem[hrd_req.addr];
            t_v <= trd_req.en;
            t_q <= trd_req.en ? t_next : '0;
        end
    end
endmodule

// File: rtl/rom_emu_dpram.sv
module rom_emu_dpram
    import rom_emu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        h_addr,
    input  logic [7:0]         h_wdata,
    input  logic               h_we,
    input  logic               h_re,
    output logic [7:0]         h_rdata,
    output logic               h_rvalid,
    input  logic [1:0]         mode,
    input  logic               bank_sel,
    input  logic [10:0]        t_addr,
    input  logic               t_ce0_n,
    input  logic               t_ce1_n,
    input  logic               t_oe_n,
    output logic [7:0]         t_data,
    output logic               t_drive
);
    mem_req_t wr_req, hrd_req, trd_req;

    rom_emu_host_dec u_dec (
        .h_addr (h_addr),
        .h_we   (h_we),
        .h_re   (h_re),
        .wr_req (wr_req),
        .rd_req (hrd_req)
    );

    rom_emu_tgt_map u_map (
        .mode     (mode),
        .bank_sel (bank_sel),
        .t_addr   (t_addr),
        .t_ce0_n  (t_ce0_n),
        .t_ce1_n  (t_ce1_n),
        .t_oe_n   (t_oe_n),
        .req      (trd_req)
    );

    rom_emu_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .wdata   (h_wdata),
        .hrd_req (hrd_req),
        .trd_req (trd_req),
        .h_q     (h_rdata),
        .h_v     (h_rvalid),
        .t_q     (t_data),
        .t_v     (t_drive)
    );
endmodule

// File: rtl/rom_emu_dpram_chk.sv
module rom_emu_dpram_chk
    import rom_emu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [15:0] h_addr,
    input logic [7:0]  h_wdata,
    input logic        h_we,
    input logic        h_re,
    input logic        h_rvalid,
    input logic [1:0]  mode,
    input logic [10:0] t_addr,
    input logic        t_ce0_n,
    input logic        t_ce1_n,
    input logic        t_oe_n,
    input logic [7:0]  t_data,
    input logic        t_drive
);
    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !t_drive |-> t_data == 8'h00);

    // R5
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $past(t_oe_n) |-> !t_drive);

    // R7
    pair_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode == 2'd2 && t_ce0_n && t_ce1_n) |-> !t_drive);

    // R9
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mode == 2'd3) |-> !t_drive);

    // R2
    rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
        h_rvalid |-> $past(h_re && !h_we && in_window(h_addr)));

    // R8
    wr_first_chk: assert property (@(posedge clk) disable iff (rst)
        $past(h_we && in_window(h_addr) && mode == 2'd1 && !t_ce0_n && !t_oe_n
              && t_addr == h_addr[10:0])
        |-> (t_drive && t_data == $past(h_wdata)));
endmodule

bind rom_emu_dpram rom_emu_dpram_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .h_addr   (h_addr),
    .h_wdata  (h_wdata),
    .h_we     (h_we),
    .h_re     (h_re),
    .h_rvalid (h_rvalid),
    .mode     (mode),
    .t_addr   (t_addr),
    .t_ce0_n  (t_ce0_n),
    .t_ce1_n  (t_ce1_n),
    .t_oe_n   (t_oe_n),
    .t_data   (t_data),
    .t_drive  (t_drive)
);

// File: tb/rom_emu_dpram_tb.sv
`timescale 1ns/1ps
module rom_emu_dpram_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] h_addr;
    logic [7:0]  h_wdata;
    logic        h_we, h_re;
    logic [7:0]  h_rdata;
    logic        h_rvalid;
    logic [1:0]  mode;
    logic        bank_sel;
    logic [10:0] t_addr;
    logic        t_ce0_n, t_ce1_n, t_oe_n;
    logic [7:0]  t_data;
    logic        t_drive;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    rom_emu_dpram u_dut (.*);

    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] ha;
        logic [7:0]  hd;
        logic        we;
        logic [1:0]  md;
        logic        bk;
        logic [10:0] ta;
        logic        c0n;
        logic        c1n;
        logic        oen;
        logic        x_drv;
        logic [7:0]  x_dat;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        // R4 preload writes, socket idle
        '{4'd4, 16'hC000, 8'h11, 1'b1, 2'd1, 1'b0, 11'h000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{4'd4, 16'hC7FF, 8'h22, 1'b1, 2'd1, 1'b0, 11'h000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{4'd4, 16'hC400, 8'h33, 1'b1, 2'd1, 1'b0, 11'h000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{4'd4, 16'hC3FF, 8'h44, 1'b1, 2'd1, 1'b0, 11'h000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        // R4 2K reads
        '{4'd4, 16'h0000, 8'h00, 1'b0, 2'd1, 1'b0, 11'h000, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11},
        '{4'd4, 16'h0000, 8'h00, 1'b0, 2'd1, 1'b0, 11'h7FF, 1'b0, 1'b0, 1'b0, 1'b1, 8'h22},
        // R6 1K mode, bit 10 ignored, bank selects half
        '{4'd6, 16'h0000, 8'h00, 1'b0, 2'd0, 1'b0, 11'h400, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11},
        '{4'd6, 16'h0000, 8'h00, 1'b0, 2'd0, 1'b1, 11'h3FF, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22},
        // R7 pair mode
        '{4'd7, 16'h0000, 8'h00, 1'b0, 2'd2, 1'b1, 11'h7FF, 1'b0, 1'b1, 1'b0, 1'b1, 8'h44},
        '{4'd7, 16'h0000, 8'h00, 1'b0, 2'd2, 1'b0, 11'h000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33},
        '{4'd7, 16'h0000, 8'h00, 1'b0, 2'd2, 1'b0, 11'h400, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11},
        '{4'd5, 16'h0000, 8'h00, 1'b0, 2'd2, 1'b0, 11'h000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        // R9 reserved mode
        '{4'd9, 16'h0000, 8'h00, 1'b0, 2'd3, 1'b0, 11'h000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        // R5 output enable high
        '{4'd5, 16'h0000, 8'h00, 1'b0, 2'd1, 1'b0, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
        // R8 collision, write-first
        '{4'd8, 16'hC123, 8'h5A, 1'b1, 2'd1, 1'b0, 11'h123, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5A},
        // R3 writes outside window, low bits alias offset 0
        '{4'd3, 16'hC800, 8'hEE, 1'b1, 2'd1, 1'b0, 11'h000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{4'd3, 16'h4000, 8'hEE, 1'b1, 2'd1, 1'b0, 11'h000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
        '{4'd3, 16'h0000, 8'h00, 1'b0, 2'd1, 1'b0, 11'h000, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11}
    };

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        h_addr = '0; h_wdata = '0; h_we = 0; h_re = 0;
        mode = 2'd1; bank_sel = 0; t_addr = '0;
        t_ce0_n = 1; t_ce1_n = 1; t_oe_n = 1;
    endtask

    // drive at negedge, clock in, sample at the following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk);
        step();
        // R1 reset state
        check("R1 t_drive/t_data", {t_drive, t_data}, 9'h000);
        check("R1 h_rvalid/h_rdata", {h_rvalid, h_rdata}, 9'h000);
        rst = 0;
        step();
        check("R1 after release", {t_drive, h_rvalid}, 9'h000);

        for (int i = 0; i < NV; i++) begin
            h_addr = TBL[i].ha; h_wdata = TBL[i].hd; h_we = TBL[i].we; h_re = 0;
            mode = TBL[i].md; bank_sel = TBL[i].bk; t_addr = TBL[i].ta;
            t_ce0_n = TBL[i].c0n; t_ce1_n = TBL[i].c1n; t_oe_n = TBL[i].oen;
            step();
            check($sformatf("R%0d row %0d", TBL[i].req, i),
                  {t_drive, t_data}, {TBL[i].x_drv, TBL[i].x_dat});
        end
        idle_inputs();

        // R2 host read inside window
        h_addr = 16'hC7FF; h_re = 1;
        step();
        check("R2 host read C7FF", {h_rvalid, h_rdata}, {1'b1, 8'h22});
        h_addr = 16'hC3FF;
        step();
        check("R2 host read C3FF", {h_rvalid, h_rdata}, {1'b1, 8'h44});

        // R3 host read outside window
        h_addr = 16'h0800;
        step();
        check("R3 read outside", {8'h00, h_rvalid}, 9'h000);

        // R10 write and read together
        h_addr = 16'hC000; h_wdata = 8'h77; h_we = 1; h_re = 1;
        step();
        check("R10 no rvalid", {8'h00, h_rvalid}, 9'h000);
        h_we = 0;
        step();
        check("R10 write landed", {h_rvalid, h_rdata}, {1'b1, 8'h77});
        h_re = 0;

        // R2 host write visible on next target read
        h_addr = 16'hC555; h_wdata = 8'hA5; h_we = 1;
        step();
        h_we = 0; t_addr = 11'h555; t_ce0_n = 0; t_oe_n = 0;
        step();
        check("R2 host write seen by socket", {t_drive, t_data}, {1'b1, 8'hA5});

        // R1 reset while driving
        rst = 1;
        step();
        check("R1 reset clears drive", {t_drive, t_data}, 9'h000);
        rst = 0;
        idle_inputs();
        step();
        check("R5 idle after reset", {t_drive, t_data}, 9'h000);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule